// File: doc/BRIEF.md
# Cache-Maintenance Instruction Decoder

This is a purely combinational decoder for 32-bit instruction words. It finds the words that ask the memory hierarchy for cache work and sorts them into a small set of classes. Two prefetch forms take a fixed block size and reuse the immediate-arithmetic and register-arithmetic opcodes with a zero destination. Two range forms, one over addresses and one over structure indices, and a completion fence share a single parameterised major opcode.

Inside the range space the opcode and function bits do not settle the class. The register fields decide it. Which fields are zero matters, and so does whether the destination matches the first source. The decoder reports the class and the 7-bit operation specifier. It passes on the three register numbers and gives the prefetch offset as a sign-extended value. A word that lands in the range space but breaks the register rules gets an illegal flag, so the core can raise an exception or send the word elsewhere.

Top module: `cmo_decoder`

## Requirements
- R1: A word with bits 6:0 = 0010011, bits 14:12 = 110 and bits 11:7 = 0 decodes as read prefetch (`cls_o` = 1).
- R2: A word with bits 6:0 = 0110011, bits 14:12 = 110 and bits 11:7 = 0 decodes as write prefetch (`cls_o` = 2).
- R3: A prefetch-opcode word with a non-zero rd, or with bits 14:12 other than 110, decodes as none (`cls_o` = 0) with `illegal_o` low.
- R4: For both prefetch classes, `offset_o` is bits 31:20 sign-extended to XLEN. For every other class it is zero.
- R5: In the range space (bits 6:0 = RANGE_OPC, bits 14:12 = 100 or 101), rd = rs1 ≠ 0 with rs2 ≠ 0 decodes as address range (`cls_o` = 3).
- R6: In the range space, rd = rs1 ≠ 0 with rs2 = 0 decodes as index range (`cls_o` = 4).
- R7: Bits 14:12 = 101 with rd = 0 and rs1 = 0 decodes as completion fence (`cls_o` = 5), whatever rs2 holds. With bits 14:12 = 100 the same register pattern is illegal.
- R8: Any other range-space word (rd = 0, rs1 = 0, or rd ≠ rs1, when it is not a fence) sets `illegal_o` and gives `cls_o` = 0.
- R9: Words outside both spaces give `cls_o` = 0, `illegal_o` low, and `spec_o` and `offset_o` both zero.
- R10: Every word maps to exactly one class. When several rules could apply, fence wins over index range, index range over address range, and address range over the prefetches.
- R11: `spec_o` carries bits 31:25 for classes 3, 4 and 5 and is zero otherwise. `rd_o`, `rs1_o` and `rs2_o` always carry bits 11:7, 19:15 and 24:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to classify |
| cls_o | output | 3 | Class code: 0 none, 1 read prefetch, 2 write prefetch, 3 address range, 4 index range, 5 completion fence |
| spec_o | output | 7 | Operation specifier for range and fence classes |
| rd_o | output | 5 | Destination register number |
| rs1_o | output | 5 | First source register number |
| rs2_o | output | 5 | Second source register number |
| offset_o | output | XLEN | Sign-extended prefetch offset |
| illegal_o | output | 1 | Range-space word that breaks the register rules |

## Verification
The bench sweeps zero and non-zero values of rd, rs1 and rs2, with rd equal to rs1 and with rd not equal to rs1, under both range function codes. The sweep exposes a decoder that tests only rs1 for zero, because such a decoder would accept rd ≠ rs1 as a valid range. It also exposes a decoder that treats function 100 with zero registers as a fence. Directed words cover the most positive and most negative immediates. An offset that is zero-extended would show up as a large positive value. The directed words also include a prefetch opcode with a non-zero rd. A decoder that ignores rd there would turn a plain arithmetic instruction into a prefetch.

// File: rtl/cmo_dec_pkg.sv
package cmo_dec_pkg;
  localparam int ILEN   = 32;
  localparam int REG_W  = 5;
  localparam int SPEC_W = 7;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int IMM_W  = SPEC_W + REG_W;

  typedef enum logic [2:0] {
    CLS_NONE       = 3'd0,
    CLS_PF_RD      = 3'd1,
    CLS_PF_WR      = 3'd2,
    CLS_RANGE_ADDR = 3'd3,
    CLS_RANGE_IDX  = 3'd4,
    CLS_FENCE      = 3'd5
  } cmo_cls_e;

  localparam int NUM_CLS = 6;

  typedef struct packed {
    logic [SPEC_W-1:0] spec;
    logic [REG_W-1:0]  rs2;
    logic [REG_W-1:0]  rs1;
    logic [F3_W-1:0]   f3;
    logic [REG_W-1:0]  rd;
    logic [OPC_W-1:0]  opc;
  } cmo_word_t;
endpackage

// File: rtl/cmo_range_dec.sv
module cmo_range_dec
  import cmo_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] RANGE_OPC = 7'b0001111
) (
  input  cmo_word_t w_i,
  output logic      fence_o,
  output logic      idx_o,
  output logic      addr_o,
  output logic      bad_o
);
  logic in_space, rd_nz, rs2_nz, pair_ok;

  always_comb begin
    in_space = (w_i.opc == RANGE_OPC) && (w_i.f3[2:1] == 2'b10);
    rd_nz    = |w_i.rd;
    rs2_nz   = |w_i.rs2;
    // rd == rs1 with rd non-zero also makes rs1 non-zero
    pair_ok  = (w_i.rd == w_i.rs1) && rd_nz;
    fence_o  = in_space && (w_i.f3 == 3'b101) && !rd_nz && (w_i.rs1 == '0);
    idx_o    = in_space && !fence_o && pair_ok && !rs2_nz;
    addr_o   = in_space && !fence_o && pair_ok && rs2_nz;
    bad_o    = in_space && !fence_o && !pair_ok;
  end

  always_comb begin
    AST_RANGE_EXCL: assert ($onehot0({fence_o, idx_o, addr_o, bad_o})); // R10
  end
endmodule

// File: rtl/cmo_pf_dec.sv
module cmo_pf_dec
  import cmo_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PF_RD_OPC = 7'b0010011,
  parameter logic [OPC_W-1:0] PF_WR_OPC = 7'b0110011,
  parameter int               XLEN      = 32
) (
  input  cmo_word_t        w_i,
  output logic             rd_hit_o,
  output logic             wr_hit_o,
  output logic [XLEN-1:0]  offset_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic             pf_shape;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sx;

  assign imm = {w_i.spec, w_i.rs2};

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_sx = imm[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    pf_shape = (w_i.f3 == 3'b110) && (w_i.rd == '0);
    rd_hit_o = pf_shape && (w_i.opc == PF_RD_OPC);
    wr_hit_o = pf_shape && (w_i.opc == PF_WR_OPC);
    offset_o = (rd_hit_o || wr_hit_o) ? imm_sx : '0;
  end
endmodule

// File: rtl/cmo_decoder.sv
module cmo_decoder
  import cmo_dec_pkg::*;
#(
  parameter logic [OPC_W-1:0] RANGE_OPC = 7'b0001111,
  parameter logic [OPC_W-1:0] PF_RD_OPC = 7'b0010011,
  parameter logic [OPC_W-1:0] PF_WR_OPC = 7'b0110011,
  parameter int               XLEN      = 32
) (
  input  logic [ILEN-1:0]   instr_i,
  output logic [2:0]        cls_o,
  output logic [SPEC_W-1:0] spec_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rs1_o,
  output logic [REG_W-1:0]  rs2_o,
  output logic [XLEN-1:0]   offset_o,
  output logic              illegal_o
);
  cmo_word_t w;
  logic fence, idx, addr, bad, pf_rd, pf_wr;
  logic [XLEN-1:0] pf_off;
  logic [NUM_CLS-1:0] cls_vec;

  assign w = cmo_word_t'(instr_i);

  cmo_range_dec #(.RANGE_OPC(RANGE_OPC)) u_range (
    .w_i(w), .fence_o(fence), .idx_o(idx), .addr_o(addr), .bad_o(bad)
  );

  cmo_pf_dec #(.PF_RD_OPC(PF_RD_OPC), .PF_WR_OPC(PF_WR_OPC), .XLEN(XLEN)) u_pf (
    .w_i(w), .rd_hit_o(pf_rd), .wr_hit_o(pf_wr), .offset_o(pf_off)
  );

  // priority: fence > index range > address range > read pf > write pf
  always_comb begin
    cls_vec = '0;
    if (fence)      cls_vec[CLS_FENCE]      = 1'b1;
    else if (idx)   cls_vec[CLS_RANGE_IDX]  = 1'b1;
    else if (addr)  cls_vec[CLS_RANGE_ADDR] = 1'b1;
    else if (pf_rd) cls_vec[CLS_PF_RD]      = 1'b1;
    else if (pf_wr) cls_vec[CLS_PF_WR]      = 1'b1;
    else            cls_vec[CLS_NONE]       = 1'b1;
  end

  always_comb begin
    cls_o = '0;
    for (int i = 0; i < NUM_CLS; i++)
      if (cls_vec[i]) cls_o = 3'(i);
  end

  always_comb begin
    rd_o      = w.rd;
    rs1_o     = w.rs1;
    rs2_o     = w.rs2;
    spec_o    = (fence || idx || addr) ? w.spec : '0;
    offset_o  = (cls_vec[CLS_PF_RD] || cls_vec[CLS_PF_WR]) ? pf_off : '0;
    illegal_o = bad;
  end

  always_comb begin
    AST_ONE_CLASS: assert ($onehot(cls_vec)); // R10
    AST_ILL_NO_CLASS: assert (!illegal_o || cls_o == CLS_NONE); // R8
    AST_FENCE_REGS: assert (cls_o != CLS_FENCE || (rd_o == '0 && rs1_o == '0)); // R7
    AST_ADDR_PAIR: assert (cls_o != CLS_RANGE_ADDR || (rd_o == rs1_o && rs2_o != '0)); // R5
    AST_IDX_PAIR: assert (cls_o != CLS_RANGE_IDX || (rd_o == rs1_o && rs2_o == '0)); // R6
    AST_PF_RD_ZERO: assert (!(cls_o == CLS_PF_RD || cls_o == CLS_PF_WR) || rd_o == '0); // R1
    AST_OFF_ZERO: assert ((cls_o == CLS_PF_RD || cls_o == CLS_PF_WR) || offset_o == '0); // R4
    AST_SPEC_ZERO: assert (cls_o inside {CLS_RANGE_ADDR, CLS_RANGE_IDX, CLS_FENCE} || spec_o == '0); // R11
  end
endmodule

// File: tb/cmo_decoder_bench.sv
module cmo_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OPC_RNG = 7'b0001111;
  localparam logic [6:0] OPC_RD  = 7'b0010011;
  localparam logic [6:0] OPC_WR  = 7'b0110011;

  typedef struct packed {
    logic [31:0] instr;
    logic [2:0]  cls;
    logic        ill;
    logic [6:0]  spec;
    logic [31:0] off;
  } vec_t;

  function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{ {12'h7ff, 5'd3, 3'b110, 5'd0, OPC_RD}, 3'd1, 1'b0, 7'h00, 32'h0000_07ff },             // R1 R4
    '{ {12'h800, 5'd3, 3'b110, 5'd0, OPC_RD}, 3'd1, 1'b0, 7'h00, 32'hffff_f800 },             // R4
    '{ {7'h55, 5'd9, 5'd4, 3'b110, 5'd0, OPC_WR}, 3'd2, 1'b0, 7'h00, 32'hffff_faa9 },         // R2
    '{ {12'h123, 5'd3, 3'b110, 5'd1, OPC_RD}, 3'd0, 1'b0, 7'h00, 32'h0 },                     // R3
    '{ {12'h123, 5'd3, 3'b111, 5'd0, OPC_RD}, 3'd0, 1'b0, 7'h00, 32'h0 },                     // R3
    '{ {7'h01, 5'd2, 5'd4, 3'b110, 5'd6, OPC_WR}, 3'd0, 1'b0, 7'h00, 32'h0 },                 // R3
    '{ {7'h2a, 5'd7, 5'd5, 3'b100, 5'd5, OPC_RNG}, 3'd3, 1'b0, 7'h2a, 32'h0 },                // R5
    '{ {7'h33, 5'd0, 5'd9, 3'b101, 5'd9, OPC_RNG}, 3'd4, 1'b0, 7'h33, 32'h0 },                // R6
    '{ {7'h11, 5'd13, 5'd0, 3'b101, 5'd0, OPC_RNG}, 3'd5, 1'b0, 7'h11, 32'h0 },               // R7
    '{ {7'h11, 5'd13, 5'd0, 3'b100, 5'd0, OPC_RNG}, 3'd0, 1'b1, 7'h00, 32'h0 },               // R7 R8
    '{ {7'h0f, 5'd1, 5'd4, 3'b100, 5'd3, OPC_RNG}, 3'd0, 1'b1, 7'h00, 32'h0 },                // R8
    '{ {7'h0f, 5'd1, 5'd4, 3'b000, 5'd3, OPC_RNG}, 3'd0, 1'b0, 7'h00, 32'h0 },                // R9
    '{ {7'h7f, 5'd1, 5'd4, 3'b110, 5'd0, OPC_RNG}, 3'd0, 1'b0, 7'h00, 32'h0 }                 // R9
  };

  logic        clk = 1'b0;
  logic [31:0] instr_i;
  logic [2:0]  cls_o;
  logic [6:0]  spec_o;
  logic [4:0]  rd_o, rs1_o, rs2_o;
  logic [31:0] offset_o;
  logic        illegal_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmo_decoder u_cmo_decoder (
    .instr_i(instr_i), .cls_o(cls_o), .spec_o(spec_o), .rd_o(rd_o), .rs1_o(rs1_o),
    .rs2_o(rs2_o), .offset_o(offset_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s word=%08h act=%08h exp=%08h", req, instr_i, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] v);
    @(negedge clk);
    instr_i = v;
    #1;
  endtask

  initial begin
    instr_i = '0;
    #1;
    check("R9 idle cls", {29'd0, cls_o}, 32'd0);
    check("R9 idle ill", {31'd0, illegal_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].instr);
      check("R10 table cls", {29'd0, cls_o}, {29'd0, VECS[i].cls});
      check("R8 table ill", {31'd0, illegal_o}, {31'd0, VECS[i].ill});
      check("R11 table spec", {25'd0, spec_o}, {25'd0, VECS[i].spec});
      check("R4 table off", offset_o, VECS[i].off);
    end

    // register sweep over the range space
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          for (int f = 0; f < 2; f++) begin
            logic [4:0] rd, rs1, rs2;
            logic [2:0] f3, ecls;
            logic eill;
            logic [6:0] f7, espec;
            rd  = (a == 0) ? 5'd0 : (a == 1) ? 5'd6 : 5'd31;
            rs1 = (b == 0) ? 5'd0 : (b == 1) ? 5'd6 : 5'd31;
            rs2 = (c == 0) ? 5'd0 : 5'd17;
            f3  = (f == 0) ? 3'b100 : 3'b101;
            f7  = 7'(a * 19 + b * 7 + c * 3 + f + 1);
            ecls = 3'd0; eill = 1'b0;
            if (f3 == 3'b101 && rd == 0 && rs1 == 0) ecls = 3'd5;
            else if (rd != 0 && rd == rs1) ecls = (rs2 == 0) ? 3'd4 : 3'd3;
            else eill = 1'b1;
            espec = (ecls != 0) ? f7 : 7'd0;
            apply(mk(f7, rs2, rs1, f3, rd, OPC_RNG));
            check("R5 R6 R7 sweep cls", {29'd0, cls_o}, {29'd0, ecls});
            check("R8 sweep ill", {31'd0, illegal_o}, {31'd0, eill});
            check("R11 sweep spec", {25'd0, spec_o}, {25'd0, espec});
            check("R11 sweep regs", {17'd0, rd_o, rs1_o, rs2_o}, {17'd0, rd, rs1, rs2});
            check("R4 sweep off", offset_o, 32'd0);
          end

    // prefetch rd sweep: only rd zero hits
    for (int r = 0; r < 3; r++) begin
      logic [4:0] rd;
      rd = (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : 5'd30;
      apply(mk(7'h00, 5'd8, 5'd2, 3'b110, rd, OPC_WR));
      check("R2 R3 pf rd sweep", {29'd0, cls_o}, (rd == 0) ? 32'd2 : 32'd0);
      check("R4 pf rd sweep off", offset_o, (rd == 0) ? 32'd8 : 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule